// File: doc/BRIEF.md
# Serial Port Modem Control and Status Unit

This block holds the modem-control register of a classic asynchronous serial port and builds its modem-status byte. Software writes a five-bit control word that drives the active-low handshake outputs (data terminal ready, request to send, two general-purpose outputs) and selects a loopback mode. The four active-low handshake inputs (clear to send, data set ready, ring indicator, carrier detect) are synchronized, reported as asserted-high levels, and watched for changes. Each change is latched as a sticky delta flag until the status byte is read.

Any latched delta, when the modem-status interrupt is enabled, raises an interrupt request. The surrounding interrupt logic reports this source with identification code 0x00. In loopback mode the control bits are wired internally onto the status inputs, the external control pins are parked inactive, and the serial transmit stream is turned back into the receive path while the external transmit line idles high. Bus decoding and interrupt prioritization live outside this block.

Top module: `modem_ctl_stat`

## Requirements
- R1: After reset, mcr_o is 0, all four control pins are 1 (inactive), msr_o is 0x00 and irq_o is 0.
- R2: A write strobe loads wdata_i into the control register, visible on mcr_o after the next rising edge. The bit map is: bit 0 DTR, bit 1 RTS, bit 2 OUT1, bit 3 OUT2, bit 4 loopback.
- R3: Outside loopback, each control pin drives the inverse of its register bit.
- R4: msr_o bits 4, 5, 6 and 7 report the complement of cts_ni, dsr_ni, ri_ni and dcd_ni. Each input passes through a two-flop synchronizer, so a pin change appears after the second rising edge.
- R5: msr_o bit 0 (CTS), bit 1 (DSR) and bit 3 (DCD) are delta flags. Each one sets one edge after its synchronized level changes in either direction.
- R6: msr_o bit 2 sets only when the ring indicator goes from asserted to deasserted (pin low to high), never on assertion.
- R7: Delta flags hold until a cycle with msr_rd_i high, which clears them at that edge. A delta that sets at the same edge as the read stays set.
- R8: irq_o is 1 exactly when msi_en_i is 1 and at least one delta flag is set.
- R9: In loopback, RTS feeds CTS, DTR feeds DSR, OUT1 feeds RI and OUT2 feeds DCD. The external status pins have no effect on msr_o.
- R10: In loopback, all control pins and tx_o are held at 1 and rx_o follows sout_i. Outside loopback, tx_o follows sout_i and rx_o follows sin_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mcr_wr_i | input | 1 | Control register write strobe |
| wdata_i | input | 5 | Control register write data |
| msr_rd_i | input | 1 | Status register read strobe (clears deltas) |
| msi_en_i | input | 1 | Modem-status interrupt enable |
| cts_ni | input | 1 | Clear to send pin, active low |
| dsr_ni | input | 1 | Data set ready pin, active low |
| ri_ni | input | 1 | Ring indicator pin, active low |
| dcd_ni | input | 1 | Carrier detect pin, active low |
| sout_i | input | 1 | Serial data from the transmitter |
| sin_i | input | 1 | Serial data from the external line |
| dtr_no | output | 1 | Data terminal ready pin, active low |
| rts_no | output | 1 | Request to send pin, active low |
| out1_no | output | 1 | General output 1, active low |
| out2_no | output | 1 | General output 2 (interrupt gate), active low |
| tx_o | output | 1 | External transmit line |
| rx_o | output | 1 | Serial data to the receiver |
| mcr_o | output | 5 | Control register readback |
| msr_o | output | 8 | Modem status byte |
| irq_o | output | 1 | Modem-status interrupt request |

## Verification
Single-pin transitions on CTS, DSR and DCD are driven in both directions and sampled edge by edge. This separates the synchronizer latency from the delta latency and confirms that either polarity sets a delta. The ring input is asserted and then released, so a flag on assertion can be told apart from one on release. A read strobe placed on the same edge as a new delta shows whether the clear swallows a fresh event. Loopback runs with conflicting external pin levels and several control words, which exposes any leak from the external pins or any swapped internal route.

// File: rtl/modem_pkg.sv
package modem_pkg;
  localparam int unsigned LINES = 4;
  localparam int unsigned MCR_W = 5;
  localparam int unsigned MSR_W = 2 * LINES;
  // control register bit map
  localparam int unsigned B_DTR  = 0;
  localparam int unsigned B_RTS  = 1;
  localparam int unsigned B_OUT1 = 2;
  localparam int unsigned B_OUT2 = 3;
  localparam int unsigned B_LOOP = 4;
  // status line order (delta and level fields share it)
  localparam int unsigned L_CTS = 0;
  localparam int unsigned L_DSR = 1;
  localparam int unsigned L_RI  = 2;
  localparam int unsigned L_DCD = 3;
endpackage

// File: rtl/mcr_reg.sv
module mcr_reg
  import modem_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [MCR_W-1:0] wdata_i,
  output logic [MCR_W-1:0] mcr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mcr_o <= '0;
    else if (wr_i) mcr_o <= wdata_i;
  end

  assert_mcr_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (mcr_o == $past(wdata_i)));
endmodule

// File: rtl/loop_route.sv
module loop_route
  import modem_pkg::*;
(
  input  logic [MCR_W-1:0] mcr_i,
  input  logic [LINES-1:0] pin_ni,
  input  logic             sout_i,
  input  logic             sin_i,
  output logic [LINES-1:0] line_no,
  output logic [LINES-1:0] ctl_no,
  output logic             tx_o,
  output logic             rx_o
);
  logic loop;
  logic [LINES-1:0] lb_n;
  assign loop = mcr_i[B_LOOP];

  // internal cross-wiring, active low like the pins
  always_comb begin
    lb_n        = '1;
    lb_n[L_CTS] = ~mcr_i[B_RTS];
    lb_n[L_DSR] = ~mcr_i[B_DTR];
    lb_n[L_RI]  = ~mcr_i[B_OUT1];
    lb_n[L_DCD] = ~mcr_i[B_OUT2];
  end

  assign line_no = loop ? lb_n : pin_ni;
  assign ctl_no  = loop ? '1 : ~mcr_i[LINES-1:0];
  assign tx_o    = loop ? 1'b1 : sout_i;
  assign rx_o    = loop ? sout_i : sin_i;
endmodule

// File: rtl/line_sync.sv
module line_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_ni,
  output logic [WIDTH-1:0] q_no
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '1;  // idle = deasserted
      else         chain_q <= {chain_q[STAGES-2:0], d_ni[g]};
    end
    assign q_no[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/delta_det.sv
module delta_det
  import modem_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] sync_ni,
  input  logic             rd_i,
  output logic [LINES-1:0] delta_o
);
  logic [LINES-1:0] prev_q, hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= sync_ni;
  end

  for (genvar g = 0; g < LINES; g++) begin : g_hit
    if (g == L_RI) begin : g_trail
      assign hit[g] = !prev_q[g] && sync_ni[g];  // asserted -> released
    end else begin : g_any
      assign hit[g] = prev_q[g] != sync_ni[g];
    end
  end

  // a fresh event outranks the clearing read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   delta_o <= '0;
    else if (rd_i) delta_o <= hit;
    else           delta_o <= delta_o | hit;
  end

  assert_ring_trailing_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(delta_o[L_RI]) |-> $past(!prev_q[L_RI] && sync_ni[L_RI]));
  assert_delta_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> ((delta_o & $past(delta_o)) == $past(delta_o)));
  assert_read_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && sync_ni == prev_q) |=> (delta_o == '0));
  assert_cts_change_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prev_q[L_CTS] != sync_ni[L_CTS]) |=> delta_o[L_CTS]);
endmodule

// File: rtl/modem_ctl_stat.sv
module modem_ctl_stat
  import modem_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mcr_wr_i,
  input  logic [MCR_W-1:0] wdata_i,
  input  logic             msr_rd_i,
  input  logic             msi_en_i,
  input  logic             cts_ni,
  input  logic             dsr_ni,
  input  logic             ri_ni,
  input  logic             dcd_ni,
  input  logic             sout_i,
  input  logic             sin_i,
  output logic             dtr_no,
  output logic             rts_no,
  output logic             out1_no,
  output logic             out2_no,
  output logic             tx_o,
  output logic             rx_o,
  output logic [MCR_W-1:0] mcr_o,
  output logic [MSR_W-1:0] msr_o,
  output logic             irq_o
);
  logic [LINES-1:0] pin_n, line_n, sync_n, delta, ctl_n;

  assign pin_n[L_CTS] = cts_ni;
  assign pin_n[L_DSR] = dsr_ni;
  assign pin_n[L_RI]  = ri_ni;
  assign pin_n[L_DCD] = dcd_ni;

  mcr_reg i_mcr (
    .clk_i, .rst_ni, .wr_i(mcr_wr_i), .wdata_i, .mcr_o
  );

  loop_route i_route (
    .mcr_i(mcr_o), .pin_ni(pin_n), .sout_i, .sin_i,
    .line_no(line_n), .ctl_no(ctl_n), .tx_o, .rx_o
  );

  line_sync #(.WIDTH(LINES), .STAGES(2)) i_sync (
    .clk_i, .rst_ni, .d_ni(line_n), .q_no(sync_n)
  );

  delta_det i_delta (
    .clk_i, .rst_ni, .sync_ni(sync_n), .rd_i(msr_rd_i), .delta_o(delta)
  );

  assign dtr_no  = ctl_n[B_DTR];
  assign rts_no  = ctl_n[B_RTS];
  assign out1_no = ctl_n[B_OUT1];
  assign out2_no = ctl_n[B_OUT2];
  assign msr_o   = {~sync_n, delta};
  assign irq_o   = msi_en_i && (|delta);

  assert_irq_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (msi_en_i && msr_o[LINES-1:0] != '0));
  assert_loop_park_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mcr_o[B_LOOP] |-> (dtr_no && rts_no && out1_no && out2_no && tx_o));
endmodule

// File: tb/test_modem_ctl_stat.sv
module test_modem_ctl_stat;
  logic clk = 0, rst_ni = 0;
  logic mcr_wr = 0, msr_rd = 0, msi_en = 0;
  logic [4:0] wdata = 0;
  logic cts_n = 1, dsr_n = 1, ri_n = 1, dcd_n = 1, sout = 1, sin = 1;
  logic dtr_no, rts_no, out1_no, out2_no, tx_o, rx_o, irq_o;
  logic [4:0] mcr_o;
  logic [7:0] msr_o;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  modem_ctl_stat i_modem_ctl_stat (
    .clk_i(clk), .rst_ni, .mcr_wr_i(mcr_wr), .wdata_i(wdata), .msr_rd_i(msr_rd),
    .msi_en_i(msi_en), .cts_ni(cts_n), .dsr_ni(dsr_n), .ri_ni(ri_n), .dcd_ni(dcd_n),
    .sout_i(sout), .sin_i(sin), .dtr_no, .rts_no, .out1_no, .out2_no, .tx_o, .rx_o,
    .mcr_o, .msr_o, .irq_o
  );

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr_mcr(logic [4:0] v);
    mcr_wr = 1; wdata = v; step(1); mcr_wr = 0;
  endtask

  task automatic rd_msr();
    msr_rd = 1; step(1); msr_rd = 0;
  endtask

  task automatic t_reset();
    step(3); rst_ni = 1; step(1);
    chk("R1", "mcr", mcr_o, 0);
    chk("R1", "ctl pins", {dtr_no, rts_no, out1_no, out2_no}, 4'hF);
    chk("R1", "msr", msr_o, 0);
    chk("R1", "irq", irq_o, 0);
  endtask

  task automatic t_mcr();
    wr_mcr(5'h0B);
    chk("R2", "mcr", mcr_o, 5'h0B);
    chk("R3", "pins 0x0B", {dtr_no, rts_no, out1_no, out2_no}, 4'b0010);
    sout = 0; #1 chk("R10", "tx follows sout", tx_o, 0);
    sin = 0;  #1 chk("R10", "rx follows sin", rx_o, 0);
    sout = 1; sin = 1;
    wr_mcr(5'h04);
    chk("R2", "mcr", mcr_o, 5'h04);
    chk("R3", "pins 0x04", {dtr_no, rts_no, out1_no, out2_no}, 4'b1101);
  endtask

  task automatic t_cts();
    cts_n = 0;
    step(1); chk("R4", "cts after 1 edge", msr_o[4], 0);
    step(1); chk("R4", "cts after 2 edges", msr_o[4], 1);
    chk("R5", "delta before 3rd edge", msr_o[0], 0);
    step(1); chk("R5", "cts delta", msr_o[3:0], 4'h1);
    chk("R8", "irq disabled", irq_o, 0);
    msi_en = 1; #1 chk("R8", "irq enabled", irq_o, 1);
    step(3); chk("R7", "delta holds", msr_o[3:0], 4'h1);
    rd_msr();
    chk("R7", "read clears", msr_o, 8'h10);
    chk("R8", "irq after read", irq_o, 0);
    cts_n = 1; step(3);
    chk("R5", "cts release delta", msr_o, 8'h01);
    rd_msr();
  endtask

  task automatic t_ring();
    ri_n = 0; step(4);
    chk("R6", "ring assert no delta", msr_o, 8'h40);
    chk("R8", "irq none", irq_o, 0);
    ri_n = 1; step(4);
    chk("R6", "ring trailing delta", msr_o, 8'h04);
    chk("R8", "irq ring", irq_o, 1);
    rd_msr();
  endtask

  task automatic t_dsr_dcd();
    dsr_n = 0; dcd_n = 0; step(4);
    chk("R5", "dsr dcd deltas", msr_o, 8'hAA);
    rd_msr();
    chk("R7", "cleared", msr_o, 8'hA0);
  endtask

  task automatic t_collide();
    dcd_n = 1; step(2);
    msr_rd = 1; step(1); msr_rd = 0;
    chk("R7", "delta kept on read edge", msr_o, 8'h28);
    rd_msr();
    dsr_n = 1; step(3); rd_msr();
    chk("R7", "idle", msr_o, 8'h00);
  endtask

  task automatic t_loop();
    wr_mcr(5'h10); step(4);
    cts_n = 0; ri_n = 0; step(4);
    chk("R9", "external ignored", msr_o, 8'h00);
    wr_mcr(5'h1F); step(4);
    chk("R9", "loop all set", msr_o, 8'hFB);
    chk("R10", "pins parked", {dtr_no, rts_no, out1_no, out2_no}, 4'hF);
    sout = 0; sin = 1; #1;
    chk("R10", "tx idle high", tx_o, 1);
    chk("R10", "rx loops sout", rx_o, 0);
    sout = 1;
    rd_msr();
    wr_mcr(5'h12); step(4);
    chk("R9", "rts->cts only", msr_o, 8'h1E);
    rd_msr();
    wr_mcr(5'h00); step(4);
    chk("R9", "external again", msr_o, 8'h50);
    sin = 0; #1 chk("R10", "rx from sin", rx_o, 0);
  endtask

  initial begin
    t_reset();
    t_mcr();
    t_cts();
    t_ring();
    t_dsr_dcd();
    t_collide();
    t_loop();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule